// File: doc/BRIEF.md
# Byte-Paired IDE Data Bridge

This block lets a host with an 8-bit, memory-mapped data path talk to a drive with a 16-bit ATA data bus. Every drive register is reached through a pair of adjacent host addresses. Address bit 0 chooses the low (even) or high (odd) half of the pair. The address bits above it choose the drive register address and the chip select.

On a write, the even access only parks its byte in a low-byte latch. The odd access then launches a single 16-bit drive write: the latched byte forms bits 7:0 and the odd access's own byte forms bits 15:8. On a read, the even access runs the drive cycle. It hands bits 7:0 to the host and keeps bits 15:8 in a high-byte latch. The odd access returns that latched byte without touching the drive.

Each drive cycle holds its strobe low for a fixed, parameterized number of clocks. The host ready line stays low for exactly that span, and the host must not issue a new request until ready returns.

Top module: `ide_byte_bridge`

## Requirements
- R1: After reset, host_ready is 1, dior_n and diow_n are 1, cs_n is 2'b11, dd_oe is 0, host_rdata is 0, and both byte latches are zero.
- R2: A write request with host_addr[0]=0 stores host_wdata in the low-byte latch. It starts no drive cycle, and host_ready stays 1.
- R3: A write request with host_addr[0]=1 starts one drive write. dd_out carries {host_wdata, low latch}, and diow_n and dd_oe are asserted for exactly STROBE_CLKS clocks with dd_out held stable.
- R4: An odd write commits even without a preceding even write. It uses the current latch value, which is zero after reset. The last of several even writes is the one used.
- R5: A read request with host_addr[0]=0 asserts dior_n for exactly STROBE_CLKS clocks. When host_ready returns, host_rdata holds drive bits 7:0, and drive bits 15:8 are kept in the high-byte latch.
- R6: A read request with host_addr[0]=1 places the high-byte latch on host_rdata in the next cycle without any drive cycle.
- R7: During a drive cycle, da equals host_addr[3:1]. cs_n is 2'b10 (first select) when host_addr[4]=0 and 2'b01 (second select) when host_addr[4]=1. Outside drive cycles cs_n is 2'b11.
- R8: host_ready is 0 exactly while a drive strobe is asserted, and at most one strobe is low at a time. Requests presented while host_ready is 0 are ignored.
- R9: A request presented in the first cycle that host_ready is back at 1 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Request, sampled when host_ready is 1 |
| host_we | input | 1 | 1 for write, 0 for read |
| host_addr | input | REG_AW+2 | Bit 0 = byte half; bits REG_AW:1 = register; top bit = select |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| host_ready | output | 1 | Idle, able to take a request |
| dd_in | input | 16 | Drive data toward the host |
| dd_out | output | 16 | Drive data toward the drive |
| dd_oe | output | 1 | Output enable for dd_out |
| dior_n | output | 1 | Drive read strobe, active low |
| diow_n | output | 1 | Drive write strobe, active low |
| da | output | REG_AW | Drive register address |
| cs_n | output | 2 | Drive chip selects, active low |

## Verification
The end of a drive strobe and the arrival of a new host request can fall on the same clock. A request arriving there must be dropped if ready is still low, and taken if ready has just returned. The bench provokes the first case by pulsing an odd write while an even read is still strobing. It judges the result by the absence of any second write strobe and an unchanged drive register in the model. It provokes the second case by raising a request on the very sample where ready is first seen high, and it checks that the reply arrives in the following cycle.

// File: rtl/ide_byte_bridge.sv
module ide_byte_bridge #(
  parameter int STROBE_CLKS = 4,
  parameter int REG_AW      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [REG_AW+1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              host_ready,
  input  logic [15:0]       dd_in,
  output logic [15:0]       dd_out,
  output logic              dd_oe,
  output logic              dior_n,
  output logic              diow_n,
  output logic [REG_AW-1:0] da,
  output logic [1:0]        cs_n
);
  localparam int AW = REG_AW + 2;
  localparam int CW = $clog2(STROBE_CLKS + 1);

  logic          busy, rd_op;
  logic [CW-1:0] cnt;
  logic [7:0]    lo_q, hi_q;
  wire           odd = host_addr[0];

  assign host_ready = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; rd_op <= 1'b0; cnt <= '0;
      lo_q <= '0; hi_q <= '0; host_rdata <= '0;
      dd_out <= '0; dd_oe <= 1'b0;
      dior_n <= 1'b1; diow_n <= 1'b1;
      da <= '0; cs_n <= 2'b11;
    end else if (busy) begin
      if (cnt == CW'(1)) begin
        busy <= 1'b0;
        dior_n <= 1'b1; diow_n <= 1'b1;
        dd_oe <= 1'b0; cs_n <= 2'b11;
        if (rd_op) begin
          host_rdata <= dd_in[7:0];
          hi_q <= dd_in[15:8];
        end
      end else begin
        cnt <= cnt - CW'(1);
      end
    end else if (host_req) begin
      if (host_we && !odd) begin
        lo_q <= host_wdata;
      end else if (!host_we && odd) begin
        host_rdata <= hi_q;
      end else begin
        busy  <= 1'b1;
        cnt   <= CW'(STROBE_CLKS);
        rd_op <= !host_we;
        da    <= host_addr[REG_AW:1];
        cs_n  <= host_addr[AW-1] ? 2'b01 : 2'b10;
        dior_n <= host_we;
        diow_n <= !host_we;
        if (host_we) begin
          dd_out <= {host_wdata, lo_q};
          dd_oe  <= 1'b1;
        end
      end
    end
  end

  logic [CW:0] sw_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sw_cnt <= '0;
    else if (busy) sw_cnt <= sw_cnt + 1'b1;
    else           sw_cnt <= '0;
  end

  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dior_n && !diow_n));
  a_r8_ready_tracks_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !host_ready |-> (!dior_n || !diow_n));
  a_r2_even_write_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_ready && host_we && !host_addr[0]) |=> (host_ready && dior_n && diow_n));
  a_r5_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_ready) |-> (sw_cnt == (CW+1)'(STROBE_CLKS)));
  a_r7_cs_select: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready ? (cs_n == 2'b11) : ($countones(~cs_n) == 1));
  a_r3_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!diow_n && $past(!diow_n)) |-> ($stable(dd_out) && dd_oe));
endmodule

// File: tb/sim_ide_byte_bridge.sv
module sim_ide_byte_bridge;
  localparam int S = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_req = 1'b0, host_we = 1'b0;
  logic [4:0] host_addr = '0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic host_ready, dd_oe, dior_n, diow_n;
  logic [15:0] dd_in, dd_out;
  logic [2:0] da;
  logic [1:0] cs_n;
  int errs = 0, checks = 0, wr_cycles = 0;
  logic [15:0] dmem [16];

  always #2 clk = ~clk;

  ide_byte_bridge #(.STROBE_CLKS(S), .REG_AW(3)) u0 (
    .clk, .rst_n, .host_req, .host_we, .host_addr, .host_wdata, .host_rdata,
    .host_ready, .dd_in, .dd_out, .dd_oe, .dior_n, .diow_n, .da, .cs_n);

  wire [3:0] idx = {cs_n == 2'b01, da};
  assign dd_in = !dior_n ? dmem[idx] : 16'hDEAD;
  always @(posedge clk) begin
    if (!diow_n) dmem[idx] <= dd_out;
    if ($fell(diow_n)) wr_cycles++;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [1:0] last_cs;
  logic [2:0] last_da;
  task automatic acc(input logic we, input logic [4:0] a, input logic [7:0] d,
                     output logic [7:0] rd, output int w);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0; w = 0;
    while (!host_ready && w < 1000) begin
      if (!dior_n || !diow_n) w++;
      last_cs = cs_n; last_da = da;
      @(negedge clk);
    end
    rd = host_rdata;
  endtask

  // we, addr, wdata, expected read byte, expected strobe clocks
  localparam logic [25:0] VEC [11] = '{
    {1'b1, 5'h02, 8'h34, 8'h00, 4'd0},
    {1'b1, 5'h03, 8'h12, 8'h00, 4'd4},
    {1'b0, 5'h02, 8'h00, 8'h34, 4'd4},
    {1'b0, 5'h03, 8'h00, 8'h12, 4'd0},
    {1'b1, 5'h1C, 8'hAA, 8'h00, 4'd0},
    {1'b1, 5'h1C, 8'hBB, 8'h00, 4'd0},
    {1'b1, 5'h1D, 8'h55, 8'h00, 4'd4},
    {1'b0, 5'h1C, 8'h00, 8'hBB, 4'd4},
    {1'b0, 5'h1D, 8'h00, 8'h55, 4'd0},
    {1'b0, 5'h04, 8'h00, 8'h00, 4'd4},
    {1'b0, 5'h05, 8'h00, 8'h77, 4'd0}
  };

  initial begin
    #(4 * 150000);
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int w, n;
    for (int i = 0; i < 16; i++) dmem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready", 16'(host_ready), 16'd1);
    chk("R1 strobes", {dior_n, diow_n}, 16'b11);
    chk("R1 cs_n", 16'(cs_n), 16'b11);
    chk("R1 oe/rdata", {dd_oe, host_rdata}, 16'h000);
    rst_n = 1'b1;
    // R1/R6: high latch zero after reset
    acc(1'b0, 5'h03, 8'h00, rd, w);
    chk("R6 odd read after reset", {8'(w), rd}, 16'h0000);
    // R4: odd write with no prior even write uses zero latch
    acc(1'b1, 5'h05, 8'h77, rd, w);
    chk("R4 width", 16'(w), 16'(S));
    chk("R4 commit", dmem[2], 16'h7700);
    // table walk: R2 R3 R5 R6 R7
    foreach (VEC[i]) begin
      acc(VEC[i][25], VEC[i][24:20], VEC[i][19:12], rd, w);
      chk("R3/R5 strobe width", 16'(w), 16'(VEC[i][3:0]));
      if (!VEC[i][25]) chk("R5/R6 read byte", 16'(rd), 16'(VEC[i][11:4]));
      if (w > 0) begin
        chk("R7 cs_n", 16'(last_cs), VEC[i][24] ? 16'b01 : 16'b10);
        chk("R7 da", 16'(last_da), 16'(VEC[i][23:21]));
      end
    end
    chk("R3 commit", dmem[1], 16'h1234);
    chk("R4 last even wins", dmem[14], 16'h55BB);
    chk("R7 other select untouched", dmem[6], 16'h0000);
    // R8: request during strobe ignored; R9: back-to-back accept
    n = wr_cycles;
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_addr = 5'h02;
    @(negedge clk);
    host_req = 1'b0;
    chk("R8 ready low in cycle", 16'(host_ready), 16'd0);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = 5'h0B; host_wdata = 8'h99;
    @(negedge clk);
    host_req = 1'b0;
    w = 0;
    while (!host_ready && w < 1000) begin w++; @(negedge clk); end
    chk("R5 read during ignore test", 16'(host_rdata), 16'h0034);
    host_req = 1'b1; host_we = 1'b0; host_addr = 5'h03;
    @(negedge clk);
    host_req = 1'b0;
    chk("R9 back-to-back odd read", 16'(host_rdata), 16'h0012);
    repeat (S + 3) @(negedge clk);
    chk("R8 no extra write cycle", 16'(wr_cycles - n), 16'd0);
    chk("R8 ignored write absent", dmem[5], 16'h0000);
    chk("R2 idle after", {host_ready, dior_n, diow_n}, 16'b111);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule